// File: doc/BRIEF.md
# Vector Lane Shuffle Unit

This block moves data around inside a 256-bit vector datapath. It takes one request per cycle and returns a registered 256-bit result. A request carries an opcode, two 256-bit register sources, a 128-bit operand from the memory side, an 8-bit immediate, a per-element control vector and a flag that selects 128-bit operation. The supported operations are:

- broadcast of a 32-, 64- or 128-bit value;
- insert of a 128-bit half;
- extract of a 128-bit half;
- element permutes on 32-bit or 64-bit elements that stay inside each 128-bit lane, driven either by the immediate or by the control vector;
- a two-source permute that assembles the result from whole 128-bit chunks and can clear either half.

The datapath is built from a parameter DW, the element width, which defaults to 32. A lane is four elements wide and the vector is two lanes wide. A result register sits at the output, and a valid strobe follows each request by exactly one cycle. The unit is meant to sit behind an issue stage. Register renaming, memory access and exceptions belong to other blocks.

Top module: `vlane_shuf`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release, before any request, res_o is all zeros and vld_o is 0.
- R2: vld_o is high in the cycle after each clock edge that samples req_i high, and low otherwise. res_o changes only on a sampled request and otherwise holds its value.
- R3: Opcodes 0, 1 and 2 broadcast a value from mem_i to every element of the result. Opcode 0 uses mem_i[31:0] for each 32-bit element, opcode 1 uses mem_i[63:0] for each 64-bit element, and opcode 2 uses mem_i[127:0] for each 128-bit half.
- R4: Opcode 3 (insert) returns src_a_i with one half replaced by mem_i[127:0]. imm_i[0]=0 replaces bits 127:0 and imm_i[0]=1 replaces bits 255:128. The other half passes through unchanged.
- R5: Opcode 4 (extract) places the half of src_a_i chosen by imm_i[0] (0 = low, 1 = high) in res_o[127:0] and clears res_o[255:128].
- R6: Opcode 5 permutes 32-bit elements by immediate. Destination element j (0..3) of each lane takes the source element of the same lane whose index is imm_i[2j+1:2j]. Both lanes use the same pattern.
- R7: Opcode 6 permutes 32-bit elements by control. Each destination element takes, from its own lane of src_a_i, the element indexed by bits 1:0 of the matching 32-bit element of ctl_i.
- R8: Opcode 7 permutes 64-bit elements by immediate. Destination element k (0..3, across the full vector) takes element imm_i[k] (0 = lower, 1 = upper) of its own lane.
- R9: Opcode 8 permutes 64-bit elements by control. The selector for destination element k is bit 1 of the matching 64-bit element of ctl_i.
- R10: Opcode 9 (chunk permute) numbers the chunks 0 = src_a_i low, 1 = src_a_i high, 2 = src_b_i low and 3 = src_b_i high. imm_i[1:0] picks the chunk for the low half of the result and imm_i[5:4] picks the chunk for the high half.
- R11: For opcode 9, imm_i[3]=1 clears the low half of the result and imm_i[7]=1 clears the high half, whatever the chunk selectors hold.
- R12: When len128_i is 1, res_o[255:128] is zero for every opcode.
- R13: Opcodes 10 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code |
| src_a_i | input | 256 | First register source |
| src_b_i | input | 256 | Second register source |
| mem_i | input | 128 | Memory-side scalar or 128-bit operand |
| imm_i | input | 8 | Immediate control byte |
| ctl_i | input | 256 | Per-element variable control |
| len128_i | input | 1 | 1 selects 128-bit operation |
| res_o | output | 256 | Registered result |
| vld_o | output | 1 | Result valid, one cycle after request |

## Verification
The bench builds the block with the default element width of 32 bits. This gives the full 256-bit vector with two 128-bit lanes, so the bench can check that no lane crossing occurs and that the two half-permute selector fields act independently. Because the opcode field is 4 bits wide, the bench can drive every code, the unused ones included. The 8-bit immediate and the 2-bit per-element control fields are small enough that randomized requests reach every selector value in both lanes, with and without the 128-bit length flag.

// File: rtl/vls_pkg.sv
package vls_pkg;

   typedef enum logic [3:0] {
      OP_BC32   = 4'd0,
      OP_BC64   = 4'd1,
      OP_BC128  = 4'd2,
      OP_INS    = 4'd3,
      OP_EXT    = 4'd4,
      OP_P32I   = 4'd5,
      OP_P32V   = 4'd6,
      OP_P64I   = 4'd7,
      OP_P64V   = 4'd8,
      OP_CHUNK  = 4'd9
   } vls_op_e;

   localparam int VLS_IMM_W = 8;
   localparam int VLS_OP_W  = 4;
   localparam int VLS_ELEMS_PER_LANE = 4;
   localparam int VLS_LANES = 2;

endpackage

// File: rtl/vls_half_move.sv
module vls_half_move
   import vls_pkg::*;
#(
   parameter int DW = 32
) (
   input  vls_op_e                 op_i,
   input  logic [4*DW-1:0]         mem_i,
   input  logic [8*DW-1:0]         src_i,
   input  logic                    hi_sel_i,
   output logic [8*DW-1:0]         vec_o
);
   localparam int LANE_W = VLS_ELEMS_PER_LANE * DW;
   localparam int VEC_W  = VLS_LANES * LANE_W;
   localparam int QW     = 2 * DW;
   localparam int N_D    = VEC_W / DW;
   localparam int N_Q    = VEC_W / QW;

   logic [N_D-1:0][DW-1:0]   bc_d;
   logic [N_Q-1:0][QW-1:0]   bc_q;
   logic [VLS_LANES-1:0][LANE_W-1:0] bc_h;
   logic [VLS_LANES-1:0][LANE_W-1:0] src_h;
   logic [VLS_LANES-1:0][LANE_W-1:0] ins_h;

   assign src_h = src_i;

   for (genvar k = 0; k < N_D; k++) begin : g_bc_d
      assign bc_d[k] = mem_i[DW-1:0];
   end

   for (genvar k = 0; k < N_Q; k++) begin : g_bc_q
      assign bc_q[k] = mem_i[QW-1:0];
   end

   for (genvar h = 0; h < VLS_LANES; h++) begin : g_half
      assign bc_h[h]  = mem_i;
      assign ins_h[h] = (hi_sel_i == h[0]) ? mem_i : src_h[h];
   end

   always_comb begin
      vec_o = '0;
      case (op_i)
         OP_BC32:  vec_o = bc_d;
         OP_BC64:  vec_o = bc_q;
         OP_BC128: vec_o = bc_h;
         OP_INS:   vec_o = ins_h;
         OP_EXT:   vec_o[LANE_W-1:0] = src_h[hi_sel_i];
         default:  vec_o = '0;
      endcase
   end

endmodule

// File: rtl/vls_lane_perm.sv
module vls_lane_perm
   import vls_pkg::*;
#(
   parameter int DW       = 32,
   parameter int LANE_IDX = 0
) (
   input  logic [4*DW-1:0]         lane_i,
   input  logic [4*DW-1:0]         ctl_i,
   input  logic [VLS_IMM_W-1:0]    imm_i,
   input  logic                    qword_i,
   input  logic                    var_i,
   output logic [4*DW-1:0]         lane_o
);
   localparam int QW    = 2 * DW;
   localparam int N_D   = VLS_ELEMS_PER_LANE;
   localparam int N_Q   = N_D / 2;
   localparam int SEL_W = $clog2(N_D);

   logic [N_D-1:0][DW-1:0] d_in, d_ctl, d_res;
   logic [N_Q-1:0][QW-1:0] q_in, q_ctl, q_res;
   logic                   ctl_unused;

   assign d_in  = lane_i;
   assign d_ctl = ctl_i;
   assign q_in  = lane_i;
   assign q_ctl = ctl_i;
   assign ctl_unused = ^ctl_i;

   for (genvar j = 0; j < N_D; j++) begin : g_dsel
      logic [SEL_W-1:0] sel;
      assign sel      = var_i ? d_ctl[j][SEL_W-1:0] : imm_i[SEL_W*j +: SEL_W];
      assign d_res[j] = d_in[sel];
   end

   for (genvar j = 0; j < N_Q; j++) begin : g_qsel
      logic sel;
      assign sel      = var_i ? q_ctl[j][1] : imm_i[N_Q*LANE_IDX + j];
      assign q_res[j] = q_in[sel];
   end

   assign lane_o = qword_i ? q_res : d_res;

endmodule

// File: rtl/vls_chunk_sel.sv
module vls_chunk_sel
   import vls_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [8*DW-1:0]         src_a_i,
   input  logic [8*DW-1:0]         src_b_i,
   input  logic [VLS_IMM_W-1:0]    imm_i,
   output logic [8*DW-1:0]         vec_o
);
   localparam int LANE_W   = VLS_ELEMS_PER_LANE * DW;
   localparam int N_PIECE  = 2 * VLS_LANES;
   localparam int FIELD_W  = VLS_IMM_W / VLS_LANES;

   logic [N_PIECE-1:0][LANE_W-1:0]   piece;
   logic [VLS_LANES-1:0][LANE_W-1:0] half;
   logic                             imm_unused;

   assign piece = {src_b_i, src_a_i};
   assign imm_unused = ^{imm_i[2], imm_i[6]};

   for (genvar h = 0; h < VLS_LANES; h++) begin : g_half
      logic [1:0] sel;
      logic       clr;
      assign sel     = imm_i[FIELD_W*h +: 2];
      assign clr     = imm_i[FIELD_W*h + 3];
      assign half[h] = clr ? '0 : piece[sel];
   end

   assign vec_o = half;

endmodule

// File: rtl/vlane_shuf.sv
module vlane_shuf
   import vls_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_i,
   input  logic [3:0]                  op_i,
   input  logic [8*DW-1:0]             src_a_i,
   input  logic [8*DW-1:0]             src_b_i,
   input  logic [4*DW-1:0]             mem_i,
   input  logic [7:0]                  imm_i,
   input  logic [8*DW-1:0]             ctl_i,
   input  logic                        len128_i,
   output logic [8*DW-1:0]             res_o,
   output logic                        vld_o
);
   localparam int LANE_W = VLS_ELEMS_PER_LANE * DW;
   localparam int VEC_W  = VLS_LANES * LANE_W;

   if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
      $error("vlane_shuf: DW must be a multiple of 8");
   end
   if (VEC_W != 8 * DW) begin : g_bad_geom
      $error("vlane_shuf: lane geometry mismatch");
   end

   vls_op_e op;
   logic    is_qword, is_var;
   logic [VEC_W-1:0] hm_vec, perm_vec, ch_vec, nxt;
   logic [VEC_W-1:0] res_q;
   logic             vld_q;

   assign op       = vls_op_e'(op_i);
   assign is_qword = (op == OP_P64I) || (op == OP_P64V);
   assign is_var   = (op == OP_P32V) || (op == OP_P64V);

   vls_half_move #(.DW(DW)) u_half (
      .op_i     (op),
      .mem_i    (mem_i),
      .src_i    (src_a_i),
      .hi_sel_i (imm_i[0]),
      .vec_o    (hm_vec)
   );

   for (genvar l = 0; l < VLS_LANES; l++) begin : g_lane
      vls_lane_perm #(.DW(DW), .LANE_IDX(l)) u_perm (
         .lane_i  (src_a_i[LANE_W*l +: LANE_W]),
         .ctl_i   (ctl_i[LANE_W*l +: LANE_W]),
         .imm_i   (imm_i),
         .qword_i (is_qword),
         .var_i   (is_var),
         .lane_o  (perm_vec[LANE_W*l +: LANE_W])
      );
   end

   vls_chunk_sel #(.DW(DW)) u_chunk (
      .src_a_i (src_a_i),
      .src_b_i (src_b_i),
      .imm_i   (imm_i),
      .vec_o   (ch_vec)
   );

   always_comb begin
      case (op)
         OP_BC32, OP_BC64, OP_BC128, OP_INS, OP_EXT: nxt = hm_vec;
         OP_P32I, OP_P32V, OP_P64I, OP_P64V:         nxt = perm_vec;
         OP_CHUNK:                                   nxt = ch_vec;
         default:                                    nxt = '0;
      endcase
      if (len128_i) begin
         nxt[VEC_W-1:LANE_W] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= req_i;
         if (req_i) begin
            res_q <= nxt;
         end
      end
   end

   assign res_o = res_q;
   assign vld_o = vld_q;

endmodule

// File: rtl/vlane_shuf_chk.sv
module vlane_shuf_chk
   import vls_pkg::*;
#(
   parameter int DW = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic [3:0]        op_i,
   input logic [4*DW-1:0]   mem_i,
   input logic [7:0]        imm_i,
   input logic              len128_i,
   input logic [8*DW-1:0]   res_o,
   input logic              vld_o
);
   localparam int LANE_W = 4 * DW;
   localparam int VEC_W  = 8 * DW;

   p_vld_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> vld_o);

   p_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !vld_o);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> $stable(res_o));

   p_bc32_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && op_i == OP_BC32) |=> (res_o[DW-1:0] == $past(mem_i[DW-1:0])));

   p_ext_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && op_i == OP_EXT) |=> (res_o[VEC_W-1:LANE_W] == '0));

   p_chunk_low_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && op_i == OP_CHUNK && imm_i[3]) |=> (res_o[LANE_W-1:0] == '0));

   p_len_upper_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && len128_i) |=> (res_o[VEC_W-1:LANE_W] == '0));

   p_bad_op_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && op_i > 4'd9) |=> (res_o == '0));

endmodule

bind vlane_shuf vlane_shuf_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_vlane_shuf.sv
`timescale 1ns/1ps
module sim_vlane_shuf;
   localparam int W = 256;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_i = 1'b0;
   logic [3:0]     op_i = '0;
   logic [W-1:0]   src_a_i = '0, src_b_i = '0, ctl_i = '0;
   logic [127:0]   mem_i = '0;
   logic [7:0]     imm_i = '0;
   logic           len128_i = 1'b0;
   logic [W-1:0]   res_o;
   logic           vld_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   logic [W-1:0] exp_res = '0;
   logic         exp_vld = 1'b0;
   string        exp_tag = "R1";

   always #2.5 clk = ~clk;

   vlane_shuf u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i),
      .src_a_i(src_a_i), .src_b_i(src_b_i), .mem_i(mem_i),
      .imm_i(imm_i), .ctl_i(ctl_i), .len128_i(len128_i),
      .res_o(res_o), .vld_o(vld_o)
   );

   function automatic logic [W-1:0] model(int op, logic [W-1:0] a, logic [W-1:0] b,
                                          logic [127:0] m, logic [7:0] imm,
                                          logic [W-1:0] c, bit len);
      logic [W-1:0] r;
      r = '0;
      case (op)
         0: for (int k = 0; k < 8; k++) r[32*k +: 32] = m[31:0];
         1: for (int k = 0; k < 4; k++) r[64*k +: 64] = m[63:0];
         2: r = {m, m};
         3: begin
            r = a;
            if (imm[0]) r[255:128] = m; else r[127:0] = m;
         end
         4: r[127:0] = imm[0] ? a[255:128] : a[127:0];
         5, 6: for (int k = 0; k < 8; k++) begin
            int lane, j, s;
            lane = k / 4; j = k % 4;
            s = (op == 5) ? int'(imm[2*j +: 2]) : int'(c[32*k +: 2]);
            r[32*k +: 32] = a[128*lane + 32*s +: 32];
         end
         7, 8: for (int k = 0; k < 4; k++) begin
            int lane, s;
            lane = k / 2;
            s = (op == 7) ? int'(imm[k]) : int'(c[64*k + 1]);
            r[64*k +: 64] = a[128*lane + 64*s +: 64];
         end
         9: for (int h = 0; h < 2; h++) begin
            int sel;
            sel = int'(imm[4*h +: 2]);
            if (!imm[4*h + 3])
               r[128*h +: 128] = (sel < 2) ? a[128*sel +: 128] : b[128*(sel-2) +: 128];
         end
         default: r = '0;
      endcase
      if (len) r[255:128] = '0;
      return r;
   endfunction

   function automatic string tag_of(int op, bit len);
      string t;
      case (op)
         0, 1, 2: t = "R3";
         3: t = "R4";
         4: t = "R5";
         5: t = "R6";
         6: t = "R7";
         7: t = "R8";
         8: t = "R9";
         9: t = "R10 R11";
         default: t = "R13";
      endcase
      if (len) t = {t, " R12"};
      return t;
   endfunction

   // reference model: one register stage, as required by R2
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_res <= '0;
         exp_vld <= 1'b0;
      end else begin
         exp_vld <= req_i;
         if (req_i) begin
            exp_res <= model(int'(op_i), src_a_i, src_b_i, mem_i, imm_i, ctl_i, len128_i);
            exp_tag <= tag_of(int'(op_i), len128_i);
         end else if (exp_tag != "R1") begin
            exp_tag <= "R2";
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         n_tests++;
         if (vld_o !== exp_vld) begin
            n_fail++;
            $display("FAIL R2 vld_o actual %0b expected %0b at %0t", vld_o, exp_vld, $time);
         end
         n_tests++;
         if (res_o !== exp_res) begin
            n_fail++;
            $display("FAIL %s res_o actual %h expected %h at %0t", exp_tag, res_o, exp_res, $time);
         end
      end
   end

   task automatic issue(int op, logic [W-1:0] a, logic [W-1:0] b, logic [127:0] m,
                        logic [7:0] imm, logic [W-1:0] c, bit len);
      @(negedge clk);
      req_i = 1'b1; op_i = op[3:0]; src_a_i = a; src_b_i = b;
      mem_i = m; imm_i = imm; ctl_i = c; len128_i = len;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_i = 1'b0;
         op_i = $urandom_range(0, 15);
         imm_i = $urandom;
         src_a_i = {8{$urandom}};
      end
   endtask

   function automatic logic [W-1:0] rnd256();
      return {$urandom, $urandom, $urandom, $urandom,
              $urandom, $urandom, $urandom, $urandom};
   endfunction

   logic [W-1:0] pat_a, pat_b;

   initial begin
      for (int k = 0; k < 8; k++) pat_a[32*k +: 32] = 32'hA000_0000 + k;
      for (int k = 0; k < 8; k++) pat_b[32*k +: 32] = 32'hB000_0000 + k;
      // R1: reset and quiet period
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // directed corners
      issue(0, pat_a, pat_b, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 8'h00, '0, 0); // R3
      issue(1, pat_a, pat_b, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 8'h00, '0, 0); // R3
      issue(2, pat_a, pat_b, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 8'h00, '0, 1); // R3 R12
      issue(3, pat_a, pat_b, {4{32'hCAFE_F00D}}, 8'h00, '0, 0); // R4 low
      issue(3, pat_a, pat_b, {4{32'hCAFE_F00D}}, 8'h01, '0, 0); // R4 high
      issue(4, pat_a, pat_b, '0, 8'h00, '0, 0); // R5 low
      issue(4, pat_a, pat_b, '0, 8'h01, '0, 0); // R5 high
      issue(5, pat_a, pat_b, '0, 8'h1B, '0, 0); // R6 reverse
      issue(5, pat_a, pat_b, '0, 8'hFF, '0, 0); // R6 all index 3
      issue(6, pat_a, pat_b, '0, 8'h00, {32'd0,32'd1,32'd2,32'd3,32'd3,32'd2,32'd1,32'd0}, 0); // R7
      issue(7, pat_a, pat_b, '0, 8'h05, '0, 0); // R8
      issue(8, pat_a, pat_b, '0, 8'h00, {64'd2, 64'd0, 64'd0, 64'd2}, 0); // R9
      issue(9, pat_a, pat_b, '0, 8'h32, '0, 0); // R10 b-high into low? sel 2 low, 3 high
      issue(9, pat_a, pat_b, '0, 8'h88, '0, 0); // R11 both cleared
      issue(9, pat_a, pat_b, '0, 8'h0B, '0, 0); // R11 low cleared
      issue(12, pat_a, pat_b, {4{32'h5A5A_5A5A}}, 8'hFF, '1, 0); // R13
      idle(3); // R2 hold
      // broad randomized coverage of opcodes, selectors and length flag
      for (int n = 0; n < 600; n++) begin
         issue($urandom_range(0, 15), rnd256(), rnd256(),
               {$urandom, $urandom, $urandom, $urandom}, 8'($urandom), rnd256(),
               ($urandom_range(0, 3) == 0));
         if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
      end
      idle(3);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired: actual hung, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule